// File: doc/BRIEF.md
# Parallel Port Handshake Slave

This block is the slave end of an 8-bit parallel link between two controllers. The master drives an active-low chip select, a read/write select and the data byte. The slave answers every byte with a four-phase handshake. It raises its handshake line once it has taken or presented the byte. It lowers the line again when the master lets go of chip select. Chip select and read/write pass through a synchronizer before the state machine sees them. A byte cycle begins on the assertion edge of chip select and ends on its release edge.

After reset the slave holds the handshake low, which tells the master it is ready. It then waits for the resync byte 0x5A. A watchdog bounds this wait, and if the window runs out the slave pulses an error and starts the sync over. Once 0x5A arrives, the slave offers 0x07 to the master's next read, and the link is then synchronized.

After sync, the first write in each transfer carries the byte count (0 to 255). The data cycles that follow move bytes into a local receive strobe or out of a local transmit source that works like a FIFO. The master picks the direction of each data cycle with its read/write line. A busy output holds local work off while a transfer is in progress.

Top module: `par_hs_slave`

States: `ST_RSY_WAIT`, `ST_RSY_DROP`, `ST_RSY_ACK`, `ST_RPL_WAIT`, `ST_RPL_DROP`, `ST_RPL_ACK`, `ST_IDLE`, `ST_IDLE_DROP`, `ST_LEN_ACK`, `ST_DATA_WAIT`, `ST_DATA_ACK`.

Transitions: all of them are taken on a chip-select edge, except the watchdog expiry.

| From | Condition | To |
|---|---|---|
| RSY_WAIT | write of 0x5A | RSY_ACK |
| RSY_WAIT | any other cycle | RSY_DROP |
| RSY_WAIT, RSY_DROP | watchdog expiry | RSY_WAIT |
| RSY_DROP | release | RSY_WAIT |
| RSY_ACK | release | RPL_WAIT |
| RPL_WAIT | read | RPL_ACK |
| RPL_WAIT | write | RPL_DROP |
| RPL_DROP | release | RPL_WAIT |
| RPL_ACK | release | IDLE |
| IDLE | write | LEN_ACK |
| IDLE | read | IDLE_DROP |
| IDLE_DROP | release | IDLE |
| LEN_ACK | release with count 0 | IDLE |
| LEN_ACK | release with nonzero count | DATA_WAIT |
| DATA_WAIT | any cycle | DATA_ACK |
| DATA_ACK | release, last byte | IDLE |
| DATA_ACK | release, more bytes | DATA_WAIT |

## Requirements
- R1: While reset is held and directly after it, hs, busy, sync_done, wd_err, data_oe, rx_valid and tx_pop are all 0.
- R2: A byte cycle raises hs only after chip select (cs_n=0) is seen, hs stays 1 for as long as cs_n is held low, and hs returns to 0 after cs_n goes back to 1.
- R3: Before sync, a write of any byte other than 0x5A, or a read, is acknowledged but ignored: no rx_valid, no tx_pop, and sync_done stays 0.
- R4: After a write of 0x5A, the next read cycle (rw=1) sees data_out=0x07 with data_oe=1, and sync_done becomes 1 once that read is released.
- R5: If 0x5A has not been accepted within WDOG_CYCLES clock cycles, wd_err pulses for exactly one cycle (about WDOG_CYCLES cycles after reset release, ±1), and the slave returns to waiting for 0x5A, which it still accepts afterwards.
- R6: Once 0x5A has been accepted, wd_err never pulses again.
- R7: After sync, the first write (rw=0) is a byte count N. For N>0, busy is 1 from the release of that cycle until the release of the Nth data cycle, then 0.
- R8: A data write cycle gives one rx_valid pulse with rx_data equal to the written byte, in order. The count byte gives no rx_valid.
- R9: A data read cycle drives data_out equal to tx_data with data_oe=1 and gives exactly one tx_pop pulse.
- R10: A count of 0 leaves busy at 0, and the next write is taken as a new count.
- R11: A count of 255 allows exactly 255 data cycles before busy falls, and the byte after that is a new count.
- R12: A read cycle after sync but outside a transfer is acknowledged with no tx_pop and no data_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Master chip select, active low |
| rw | input | 1 | Master direction: 1 = master reads, 0 = master writes |
| data_in | input | 8 | Byte from the master |
| data_out | output | 8 | Byte to the master |
| data_oe | output | 1 | Output enable for data_out |
| hs | output | 1 | Handshake acknowledge to the master |
| rx_data | output | 8 | Received byte for local logic |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| tx_data | input | 8 | Head byte of the local transmit source |
| tx_pop | output | 1 | One-cycle pop of the transmit source |
| busy | output | 1 | Transfer in progress; local activity held off |
| sync_done | output | 1 | Resync handshake completed |
| wd_err | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The resync step is tried with several inputs: wrong bytes, a read before 0x5A, letting the window run out, and finally the correct 0x5A. Together these show that only the exact code moves the slave forward. They also show that the watchdog restarts cleanly after it expires and stops for good once sync is reached.

Transfers are tried with counts of 0, 1, 4 and 255, and with mixed write and read data cycles. This separates an off-by-one in the length counter from a failure to switch direction within one transfer.

A scoreboard of expected received bytes catches any strobe that fires outside a data phase, including during sync and on the count byte. A handshake held open for several cycles shows that the acknowledge is level-held and not a pulse.

// File: rtl/par_hs_pkg.sv
package par_hs_pkg;

    typedef enum logic [3:0] {
        ST_RSY_WAIT,
        ST_RSY_DROP,
        ST_RSY_ACK,
        ST_RPL_WAIT,
        ST_RPL_DROP,
        ST_RPL_ACK,
        ST_IDLE,
        ST_IDLE_DROP,
        ST_LEN_ACK,
        ST_DATA_WAIT,
        ST_DATA_ACK
    } hs_state_e;

    localparam logic [7:0] RESYNC_CODE = 8'h5A;
    localparam logic [7:0] ACKSYNC_CODE = 8'h07;

endpackage

// File: rtl/hs_in_sync.sv
module hs_in_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hs_wdog.sv
module hs_wdog #(
    parameter int CYCLES = 8_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && (cnt_q == CNT_W'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || expire)  cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    // R5: the window counter never passes its limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CNT_W'(CYCLES)));

    // R5: after an expiry the count starts again from zero
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/hs_len_cnt.sv
module hs_len_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             empty,
    output logic             last
);

    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rem_q <= '0;
        else if (load)                     rem_q <= load_val;
        else if (dec && rem_q != '0)       rem_q <= rem_q - 1'b1;
    end

    assign empty = (rem_q == '0);
    assign last  = (rem_q == LEN_W'(1));

    // R11: a data cycle is never counted when nothing is left
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !empty);

    // R7: a load never coincides with a count-down
    p_load_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

endmodule

// File: rtl/par_hs_slave.sv
module par_hs_slave
    import par_hs_pkg::*;
#(
    parameter int WDOG_CYCLES = 8_400_000,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              hs,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              busy,
    output logic              sync_done,
    output logic              wd_err
);

    localparam int CTRL_W = 2;

    hs_state_e st_q, st_d;

    logic [CTRL_W-1:0] ctrl_s;
    logic cs_act, rw_s, cs_prev_q, cs_rise, cs_fall;
    logic wd_run, wd_exp;
    logic take_len, take_dat;
    logic len_empty, len_last;
    logic rx_valid_q, tx_pop_q, rd_q, err_q;
    logic [DATA_W-1:0] rx_q, out_q;
    logic is_resync;

    hs_in_sync #(.STAGES(SYNC_STAGES), .WIDTH(CTRL_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({~cs_n, rw}),
        .q     (ctrl_s)
    );

    assign cs_act  = ctrl_s[1];
    assign rw_s    = ctrl_s[0];
    assign cs_rise = cs_act && !cs_prev_q;
    assign cs_fall = !cs_act && cs_prev_q;

    assign wd_run = (st_q == ST_RSY_WAIT) || (st_q == ST_RSY_DROP);

    hs_wdog #(.CYCLES(WDOG_CYCLES)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wd_run),
        .expire (wd_exp)
    );

    assign take_len  = (st_q == ST_IDLE) && cs_rise && !rw_s;
    assign take_dat  = (st_q == ST_DATA_WAIT) && cs_rise;
    assign is_resync = !rw_s && (data_in == DATA_W'(RESYNC_CODE));

    hs_len_cnt #(.LEN_W(DATA_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_len),
        .load_val (data_in),
        .dec      (take_dat),
        .empty    (len_empty),
        .last     (len_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RSY_WAIT;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RSY_WAIT: begin
                if (wd_exp)         st_d = ST_RSY_WAIT;
                else if (cs_rise)   st_d = is_resync ? ST_RSY_ACK : ST_RSY_DROP;
            end
            ST_RSY_DROP: begin
                if (wd_exp || cs_fall) st_d = ST_RSY_WAIT;
            end
            ST_RSY_ACK: begin
                if (cs_fall) st_d = ST_RPL_WAIT;
            end
            ST_RPL_WAIT: begin
                if (cs_rise) st_d = rw_s ? ST_RPL_ACK : ST_RPL_DROP;
            end
            ST_RPL_DROP: begin
                if (cs_fall) st_d = ST_RPL_WAIT;
            end
            ST_RPL_ACK: begin
                if (cs_fall) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (cs_rise) st_d = rw_s ? ST_IDLE_DROP : ST_LEN_ACK;
            end
            ST_IDLE_DROP: begin
                if (cs_fall) st_d = ST_IDLE;
            end
            ST_LEN_ACK: begin
                if (cs_fall) st_d = len_empty ? ST_IDLE : ST_DATA_WAIT;
            end
            ST_DATA_WAIT: begin
                if (cs_rise) st_d = ST_DATA_ACK;
            end
            ST_DATA_ACK: begin
                if (cs_fall) st_d = len_empty ? ST_IDLE : ST_DATA_WAIT;
            end
            default: st_d = ST_RSY_WAIT;
        endcase
    end

    // Datapath registers and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b0;
            rx_valid_q <= 1'b0;
            tx_pop_q   <= 1'b0;
            rd_q       <= 1'b0;
            err_q      <= 1'b0;
            rx_q       <= '0;
            out_q      <= '0;
        end else begin
            cs_prev_q  <= cs_act;
            rx_valid_q <= take_dat && !rw_s;
            tx_pop_q   <= take_dat && rw_s;
            err_q      <= wd_exp;
            if (take_dat) begin
                rd_q <= rw_s;
                if (rw_s) out_q <= tx_data;
                else      rx_q  <= data_in;
            end
            if ((st_q == ST_RPL_WAIT) && cs_rise && rw_s) begin
                out_q <= DATA_W'(ACKSYNC_CODE);
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        hs        = 1'b0;
        data_oe   = 1'b0;
        busy      = 1'b0;
        sync_done = 1'b0;
        unique case (st_q)
            ST_RSY_WAIT, ST_RPL_WAIT: ;
            ST_RSY_DROP, ST_RSY_ACK, ST_RPL_DROP: hs = 1'b1;
            ST_RPL_ACK: begin
                hs      = 1'b1;
                data_oe = 1'b1;
            end
            ST_IDLE: sync_done = 1'b1;
            ST_IDLE_DROP, ST_LEN_ACK: begin
                hs        = 1'b1;
                sync_done = 1'b1;
            end
            ST_DATA_WAIT: begin
                busy      = 1'b1;
                sync_done = 1'b1;
            end
            ST_DATA_ACK: begin
                hs        = 1'b1;
                busy      = 1'b1;
                sync_done = 1'b1;
                data_oe   = rd_q;
            end
            default: ;
        endcase
    end

    assign data_out = out_q;
    assign rx_data  = rx_q;
    assign rx_valid = rx_valid_q;
    assign tx_pop   = tx_pop_q;
    assign wd_err   = err_q;

    // R2: the acknowledge only rises while the master selects the slave
    p_hs_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> cs_act);

    // R2: the acknowledge is held until the select is released
    p_hs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && cs_act) |=> hs);

    // R5: the error is a single-cycle pulse
    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_err |=> !wd_err);

    // R6: no watchdog error once synchronized
    p_no_err_synced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> !wd_err);

    // R8: received strobes only inside a transfer
    p_rx_in_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R9: a pop always comes with the bus being driven
    p_pop_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (data_oe && hs));

    // R12: the bus is driven only during an acknowledge
    p_oe_in_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> hs);

endmodule

// File: tb/par_hs_slave_tb.sv
module par_hs_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 400;
    localparam int HS_TMO     = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rw = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out, rx_data;
    logic       data_oe, hs, rx_valid, tx_pop, busy, sync_done, wd_err;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;
    int tx_idx = 0;
    int exp_tx = 0;
    int err_seen = 0;
    int pop_seen = 0;
    int cyc = 0;
    int err_cyc = -1;
    logic [7:0] exp_rx [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tx_data = 8'((tx_idx * 7 + 3) & 255);

    par_hs_slave #(.WDOG_CYCLES(WDOG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .hs(hs), .rx_data(rx_data),
        .rx_valid(rx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .busy(busy),
        .sync_done(sync_done), .wd_err(wd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_pop) begin
            tx_idx <= tx_idx + 1;
            pop_seen <= pop_seen + 1;
        end
    end

    // Monitor: scoreboard of received bytes and error pulses
    always @(negedge clk) begin
        if (rst_n && wd_err) begin
            err_seen++;
            if (err_cyc < 0) err_cyc = cyc;
        end
        if (rst_n && rx_valid) begin
            checks++;
            if (exp_rx.size() == 0) begin
                errors++;
                $display("FAIL R8 actual=%0h expected=none", rx_data);
            end else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                if (rx_data !== e) begin
                    errors++;
                    $display("FAIL R8 actual=%0h expected=%0h", rx_data, e);
                end
            end
        end
    end

    task automatic wait_hs(input logic lvl, input string req);
        int n;
        n = 0;
        while (hs !== lvl && n < HS_TMO) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'b0, hs}, {31'b0, lvl});
    endtask

    task automatic bus_write(input logic [7:0] b, input bit is_data, input string req);
        @(negedge clk);
        data_in = b;
        rw = 1'b0;
        if (is_data) exp_rx.push_back(b);
        @(negedge clk);
        cs_n = 1'b0;
        wait_hs(1'b1, req);
        @(negedge clk);
        cs_n = 1'b1;
        wait_hs(1'b0, req);
    endtask

    task automatic bus_read(output logic [7:0] b, output logic oe);
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        wait_hs(1'b1, "R2");
        @(negedge clk);
        b  = data_out;
        oe = data_oe;
        cs_n = 1'b1;
        wait_hs(1'b0, "R2");
        rw = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic oe;
        int base, pops0, errs0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {27'b0, hs, busy, sync_done, wd_err, data_oe}, 32'h0);
        rst_n = 1'b1;
        base = cyc;
        @(negedge clk);
        chk("R1", {26'b0, hs, busy, sync_done, wd_err, rx_valid, tx_pop}, 32'h0);

        // R5: let the window expire
        while (err_seen == 0 && (cyc - base) < WDOG + 20) @(negedge clk);
        chk("R5", {31'b0, (err_cyc - base >= WDOG - 1) && (err_cyc - base <= WDOG + 1)}, 32'h1);
        @(negedge clk);
        chk("R5", {31'b0, wd_err}, 32'h0);
        chk("R5", {31'b0, sync_done}, 32'h0);

        // R3: wrong bytes and a read before sync are ignored
        bus_write(8'h33, 1'b0, "R3");
        bus_write(8'h5B, 1'b0, "R3");
        pops0 = pop_seen;
        bus_read(b, oe);
        chk("R3", {31'b0, oe}, 32'h0);
        chk("R3", pop_seen, pops0);
        chk("R3", {31'b0, sync_done}, 32'h0);
        chk("R3", exp_rx.size(), 0);

        // R4: resync then acknowledge code
        bus_write(8'h5A, 1'b0, "R4");
        chk("R4", {31'b0, sync_done}, 32'h0);
        bus_read(b, oe);
        chk("R4", {23'b0, oe, b}, {23'b0, 1'b1, 8'h07});
        @(negedge clk);
        chk("R4", {31'b0, sync_done}, 32'h1);

        // R6: no further errors
        errs0 = err_seen;
        repeat (3 * WDOG) @(negedge clk);
        chk("R6", err_seen, errs0);

        // R2: handshake held while select stays low
        @(negedge clk);
        rw = 1'b0; data_in = 8'h00;
        @(negedge clk);
        chk("R2", {31'b0, hs}, 32'h0);
        cs_n = 1'b0;
        wait_hs(1'b1, "R2");
        repeat (6) @(negedge clk);
        chk("R2", {31'b0, hs}, 32'h1);
        cs_n = 1'b1;
        wait_hs(1'b0, "R2");
        // that was a count of 0 -> R10
        chk("R10", {31'b0, busy}, 32'h0);

        // R7/R8/R9: mixed transfer of 4
        bus_write(8'd4, 1'b0, "R7");
        chk("R7", {31'b0, busy}, 32'h1);
        bus_write(8'hA5, 1'b1, "R8");
        exp_tx = tx_idx;
        pops0 = pop_seen;
        bus_read(b, oe);
        chk("R9", {23'b0, oe, b}, {23'b0, 1'b1, 8'((exp_tx * 7 + 3) & 255)});
        chk("R9", pop_seen, pops0 + 1);
        bus_write(8'h3C, 1'b1, "R8");
        chk("R7", {31'b0, busy}, 32'h1);
        bus_write(8'h00, 1'b1, "R8");
        @(negedge clk);
        chk("R7", {31'b0, busy}, 32'h0);
        chk("R8", exp_rx.size(), 0);

        // R10: zero count then a one-byte transfer
        bus_write(8'd0, 1'b0, "R10");
        chk("R10", {31'b0, busy}, 32'h0);
        bus_write(8'd1, 1'b0, "R10");
        chk("R10", {31'b0, busy}, 32'h1);
        bus_write(8'hEE, 1'b1, "R10");
        chk("R10", {31'b0, busy}, 32'h0);

        // R12: idle read
        pops0 = pop_seen;
        bus_read(b, oe);
        chk("R12", {31'b0, oe}, 32'h0);
        chk("R12", pop_seen, pops0);
        chk("R12", {31'b0, busy}, 32'h0);

        // R11: maximum length
        bus_write(8'd255, 1'b0, "R11");
        for (int i = 0; i < 254; i++) bus_write(8'(i), 1'b1, "R11");
        chk("R11", {31'b0, busy}, 32'h1);
        bus_write(8'hFE, 1'b1, "R11");
        chk("R11", {31'b0, busy}, 32'h0);
        bus_write(8'd0, 1'b0, "R11");
        chk("R11", {31'b0, busy}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R11", exp_rx.size(), 0);
        chk("R6", err_seen, errs0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule